// File: doc/BRIEF.md
# Write-Through Invalidate/Update Snoop Cache

This block is a direct-mapped private cache that sits between one processor and a shared bus. Every store the processor issues is written through to shared memory over the bus, so memory always holds the latest value and a cached line only needs a Valid or Invalid state. The cache stays coherent by watching the writes that other agents put on the bus and either dropping or refreshing the matching line.

The line directory is read through two independent ports. One serves processor lookups and the other serves snoop lookups, so a snooped transaction is handled in the cycle it appears, even while the processor side is waiting on a fill or a store. Two configuration inputs choose the behaviour. One picks what a write miss does: send the data to memory only, or fetch the line first and then write it. The other picks what a foreign snooped write does to a matching line: invalidate it or overwrite its data. Each line holds one data word. Processor requests use a request/done handshake. Bus requests are held until the bus acknowledges them.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, and `cpu_busy`, `cpu_done` and `bus_req` are low.
- R2: The address splits into a word offset (low `log2(DATA_W/8)` bits, ignored), a line index (next `IDX_W` bits, bits 4:2 by default) and a tag (the remaining upper bits). A read whose index holds a Valid line with an equal tag is a hit: it completes with no bus transaction and with `cpu_done` high in the cycle after the request is accepted.
- R3: A read miss issues exactly one bus read (`bus_we`=0) at the request address. The returned word goes to the processor, and the line is stored as Valid. `cpu_busy` stays high from acceptance until `cpu_done`.
- R4: Every processor write, hit or miss, issues exactly one bus write carrying the address and data, and memory is updated. A write hit also updates the cached word.
- R5: With `cfg_fetch_on_write`=0, a write miss writes memory only and allocates no line. The line already held at that index stays Valid with its contents.
- R6: With `cfg_fetch_on_write`=1, a write miss first issues one bus read for the line, then the bus write. The line ends Valid and holds the written data.
- R7: With `cfg_snoop_update`=0, a snooped write from another agent whose tag matches a Valid line makes that line Invalid on the next edge.
- R8: With `cfg_snoop_update`=1, such a snooped write replaces the cached word with the snooped data, and the line stays Valid.
- R9: A snooped read, or a snooped write whose tag differs from the line at its index, leaves the cache unchanged.
- R10: A snooped transaction whose `snp_src_id` equals the block's own `AGENT_ID` is ignored in both snoop modes.
- R11: If a foreign snooped write targets the same index as a processor lookup in the same cycle, the lookup is treated as a miss. A line write from the processor side in such a cycle leaves the line Invalid.
- R12: `bus_req` stays high with stable `bus_addr` and `bus_we` until a cycle with `bus_ack` high. Read data is taken from `bus_rdata` in that cycle. `bus_req` is low whenever `cpu_busy` is low.
- R13: Snooped writes are acted on in every cycle, including while a processor miss or store is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fetch_on_write | input | 1 | 1: a write miss fetches the line before writing; 0: it writes memory only |
| cfg_snoop_update | input | 1 | 1: a foreign snooped write updates the line; 0: it invalidates the line |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | A request is in progress |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | Bus transaction is a write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_src_id | output | ID_W | Requester identity of this block (`AGENT_ID`) |
| bus_ack | input | 1 | Bus completes the current transaction |
| bus_rdata | input | DATA_W | Bus read data, valid with `bus_ack` |
| snp_valid | input | 1 | A bus transaction is visible for snooping |
| snp_we | input | 1 | Snooped transaction is a write |
| snp_addr | input | ADDR_W | Snooped address |
| snp_wdata | input | DATA_W | Snooped write data |
| snp_src_id | input | ID_W | Requester identity of the snooped transaction |

## Verification
The hardest case to reach is a processor lookup and a foreign snooped write to the same index landing in the same cycle. The bench drives both in the same half-cycle before the accepting edge. It runs this in update mode, where a design that ignored the collision would return the old cached word without a bus read. Snoops that arrive while the controller is busy are produced by forking a snoop pulse against a read miss to a different index. Whether the line survived is then judged only by counting bus reads on a later access.

// File: rtl/snc_pkg.sv
package snc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_WT   = 2'd2,
    ST_RESP = 2'd3
  } snc_state_e;
endpackage

// File: rtl/snc_dir.sv
module snc_dir #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 11,
  parameter int DATA_W = 32,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output logic              a_valid,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output logic              b_valid,
  output logic [TAG_W-1:0]  b_tag,
  input  logic              w_en,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [DATA_W-1:0] w_data,
  input  logic              s_fw,
  input  logic              s_inv,
  input  logic              s_upd,
  input  logic [DATA_W-1:0] s_data,
  output logic [LINES-1:0]  valid_vec
);
  logic [LINES-1:0]  vld_q, vld_n;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [TAG_W-1:0]  tag_n  [LINES];
  logic [DATA_W-1:0] dat_q  [LINES];
  logic [DATA_W-1:0] dat_n  [LINES];

  assign a_valid   = vld_q[a_idx];
  assign a_tag     = tag_q[a_idx];
  assign a_data    = dat_q[a_idx];
  assign b_valid   = vld_q[b_idx];
  assign b_tag     = tag_q[b_idx];
  assign valid_vec = vld_q;

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      vld_n[i] = vld_q[i];
      tag_n[i] = tag_q[i];
      dat_n[i] = dat_q[i];
      if (w_en && a_idx == IDX_W'(i)) begin
        vld_n[i] = !(s_fw && b_idx == IDX_W'(i));
        tag_n[i] = w_tag;
        dat_n[i] = w_data;
      end else if (s_inv && b_idx == IDX_W'(i)) begin
        vld_n[i] = 1'b0;
      end else if (s_upd && b_idx == IDX_W'(i)) begin
        dat_n[i] = s_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      tag_q[i] <= tag_n[i];
      dat_q[i] <= dat_n[i];
    end
  end
endmodule

// File: rtl/snc_ctrl.sv
module snc_ctrl
  import snc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fow,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_busy,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] look_addr,
  input  logic              look_hit,
  input  logic [DATA_W-1:0] look_data,
  output logic              w_en,
  output logic [DATA_W-1:0] w_data,
  output logic              cur_we
);
  snc_state_e        st_q, st_n;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdat_q, rdat_q, rdat_n;
  logic              lat_en, rd_en;

  assign look_addr = (st_q == ST_IDLE) ? cpu_addr : addr_q;
  assign cpu_busy  = (st_q != ST_IDLE);
  assign cpu_done  = (st_q == ST_RESP);
  assign cpu_rdata = rdat_q;
  assign bus_req   = (st_q == ST_FILL) || (st_q == ST_WT);
  assign bus_we    = (st_q == ST_WT);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdat_q;
  assign cur_we    = we_q;
  assign lat_en    = (st_q == ST_IDLE) && cpu_req;

  always_comb begin
    st_n   = st_q;
    rdat_n = rdat_q;
    rd_en  = 1'b0;
    w_en   = 1'b0;
    w_data = wdat_q;
    unique case (st_q)
      ST_IDLE: if (cpu_req) begin
        if (!cpu_we) begin
          if (look_hit) begin
            rd_en = 1'b1; rdat_n = look_data; st_n = ST_RESP;
          end else begin
            st_n = ST_FILL;
          end
        end else begin
          st_n = (look_hit || !cfg_fow) ? ST_WT : ST_FILL;
        end
      end
      ST_FILL: if (bus_ack) begin
        w_en   = 1'b1;
        w_data = bus_rdata;
        rd_en  = 1'b1;
        rdat_n = bus_rdata;
        st_n   = we_q ? ST_WT : ST_RESP;
      end
      ST_WT: if (bus_ack) begin
        w_en = look_hit;
        st_n = ST_RESP;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  always_ff @(posedge clk) begin
    if (lat_en) begin
      addr_q <= cpu_addr;
      we_q   <= cpu_we;
      wdat_q <= cpu_wdata;
    end
    if (rd_en) rdat_q <= rdat_n;
  end
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 3,
  parameter int ID_W     = 2,
  parameter int AGENT_ID = 1,
  localparam int OFF_W = $clog2(DATA_W / 8),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fetch_on_write,
  input  logic              cfg_snoop_update,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_busy,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [ID_W-1:0]   bus_src_id,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_we,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_wdata,
  input  logic [ID_W-1:0]   snp_src_id
);
  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  look_idx, snp_idx;
  logic [TAG_W-1:0]  look_tag, snp_tag, a_tag, b_tag;
  logic              a_valid, b_valid, look_hit, clash;
  logic [DATA_W-1:0] a_data, w_data;
  logic              w_en, cur_we, snp_fw, s_hit, s_inv, s_upd;
  logic [LINES-1:0]  line_valid;

  assign bus_src_id = ID_W'(AGENT_ID);
  assign look_idx   = look_addr[OFF_W +: IDX_W];
  assign look_tag   = look_addr[ADDR_W-1 -: TAG_W];
  assign snp_idx    = snp_addr[OFF_W +: IDX_W];
  assign snp_tag    = snp_addr[ADDR_W-1 -: TAG_W];

  assign snp_fw   = snp_valid && snp_we && (snp_src_id != ID_W'(AGENT_ID));
  assign s_hit    = snp_fw && b_valid && (b_tag == snp_tag);
  assign s_inv    = s_hit && !cfg_snoop_update;
  assign s_upd    = s_hit && cfg_snoop_update;
  assign clash    = snp_fw && (snp_idx == look_idx);
  assign look_hit = a_valid && (a_tag == look_tag) && !clash;

  snc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_fow(cfg_fetch_on_write),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .cpu_busy(cpu_busy), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .look_addr(look_addr), .look_hit(look_hit),
    .look_data(a_data), .w_en(w_en), .w_data(w_data), .cur_we(cur_we)
  );

  snc_dir #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .a_idx(look_idx), .a_valid(a_valid), .a_tag(a_tag), .a_data(a_data),
    .b_idx(snp_idx), .b_valid(b_valid), .b_tag(b_tag),
    .w_en(w_en), .w_tag(look_tag), .w_data(w_data),
    .s_fw(snp_fw), .s_inv(s_inv), .s_upd(s_upd), .s_data(snp_wdata),
    .valid_vec(line_valid)
  );
endmodule

// File: rtl/wt_snoop_cache_chk.sv
module wt_snoop_cache_chk #(
  parameter int ADDR_W   = 16,
  parameter int IDX_W    = 3,
  parameter int ID_W     = 2,
  parameter int AGENT_ID = 1,
  parameter int OFF_W    = 2,
  localparam int LINES = 1 << IDX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_done,
  input logic              cpu_busy,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snp_valid,
  input logic [ADDR_W-1:0] snp_addr,
  input logic [ID_W-1:0]   snp_src_id,
  input logic              s_inv,
  input logic              w_en,
  input logic              cur_we,
  input logic [LINES-1:0]  line_valid
);
  logic [IDX_W-1:0] s_idx;
  assign s_idx = snp_addr[OFF_W +: IDX_W];

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R12

  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_busy |-> !bus_req); // R12

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> cpu_busy); // R3

  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && cur_we |-> $past(bus_req && bus_we && bus_ack)); // R4

  AST_SNOOP_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    s_inv |=> !line_valid[$past(s_idx)]); // R7

  AST_SELF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_src_id == ID_W'(AGENT_ID) && !w_en |=> $stable(line_valid)); // R10
endmodule

bind wt_snoop_cache wt_snoop_cache_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_W(ID_W), .AGENT_ID(AGENT_ID), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
  .bus_req(bus_req), .bus_we(bus_we), .bus_ack(bus_ack), .bus_addr(bus_addr),
  .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_src_id(snp_src_id),
  .s_inv(s_inv), .w_en(w_en), .cur_we(cur_we), .line_valid(line_valid)
);

// File: tb/wt_snoop_cache_test.sv
module wt_snoop_cache_test;
  localparam int OWN = 1;
  localparam int OTHER = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_fow = 1'b0, cfg_upd = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_done, cpu_busy;
  logic bus_req, bus_we, bus_ack;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0] bus_src_id;
  logic snp_valid = 1'b0, snp_we = 1'b0;
  logic [15:0] snp_addr = '0;
  logic [31:0] snp_wdata = '0;
  logic [1:0] snp_src_id = '0;

  logic [31:0] mem [256];
  int nrd, nwr, errors, checks;
  logic [15:0] last_rd_addr;

  always #5 clk = ~clk;

  wt_snoop_cache uut (
    .clk(clk), .rst_n(rst_n), .cfg_fetch_on_write(cfg_fow), .cfg_snoop_update(cfg_upd),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_src_id(bus_src_id), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr),
    .snp_wdata(snp_wdata), .snp_src_id(snp_src_id)
  );

  // shared memory and bus responder: acknowledges one cycle after a request
  assign bus_rdata = mem[bus_addr[9:2]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA500_0000 + 32'(i) * 32'h0001_0203;
      bus_ack <= 1'b0;
      nrd <= 0;
      nwr <= 0;
    end else begin
      bus_ack <= bus_req && !bus_ack;
      if (bus_req && bus_ack && bus_we) begin
        mem[bus_addr[9:2]] <= bus_wdata;
        nwr <= nwr + 1;
      end
      if (bus_req && bus_ack && !bus_we) begin
        nrd <= nrd + 1;
        last_rd_addr <= bus_addr;
      end
      if (snp_valid && snp_we && snp_src_id != 2'(OWN))
        mem[snp_addr[9:2]] <= snp_wdata;
    end
  end

  function automatic logic [15:0] mk(input int tag, input int idx);
    return 16'((tag << 5) | (idx << 2));
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [15:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    forever begin
      @(negedge clk);
      if (cpu_done) break;
    end
    q = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  task automatic snoop(input logic we, input logic [15:0] a, input logic [31:0] d, input int id);
    @(negedge clk);
    snp_valid = 1'b1; snp_we = we; snp_addr = a; snp_wdata = d; snp_src_id = 2'(id);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic run_tests();
    logic [31:0] q, wd;
    int r0, w0, cyc;
    repeat (3) @(negedge clk);
    check("R1", "busy after reset", 32'(cpu_busy), 0);
    check("R1", "done after reset", 32'(cpu_done), 0);
    check("R1", "bus_req after reset", 32'(bus_req), 0);
    rst_n = 1'b1;

    // R1: nothing cached after reset, so the first read of every index misses
    for (int i = 0; i < 8; i++) begin
      r0 = nrd;
      cpu_op(1'b0, mk(1, i), 0, q);
      check("R1", "cold read fetches", 32'(nrd - r0), 1);
      check("R3", "miss data", q, 32'hA500_0000 + 32'((1 << 3) | i) * 32'h0001_0203);
      check("R12", "fill address", 32'(last_rd_addr), 32'(mk(1, i)));
      r0 = nrd;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = mk(1, i);
      @(negedge clk); cyc = 1;
      while (!cpu_done) begin @(negedge clk); cyc++; end
      q = cpu_rdata; cpu_req = 1'b0;
      check("R2", "hit latency", cyc, 1);
      check("R2", "hit no bus read", 32'(nrd - r0), 0);
      check("R2", "hit data", q, 32'hA500_0000 + 32'((1 << 3) | i) * 32'h0001_0203);
    end

    // R4: write hits go through to memory and update the line
    for (int i = 0; i < 8; i++) begin
      wd = 32'h5A5A_0000 | 32'(i);
      w0 = nwr;
      cpu_op(1'b1, mk(1, i), wd, q);
      check("R4", "one bus write", 32'(nwr - w0), 1);
      check("R4", "memory updated", mem[(1 << 3) | i], wd);
      r0 = nrd;
      cpu_op(1'b0, mk(1, i), 0, q);
      check("R4", "cached word updated", q, wd);
      check("R4", "still a hit", 32'(nrd - r0), 0);
    end

    // R5: direct-write miss does not allocate
    for (int i = 0; i < 8; i++) begin
      wd = 32'hD00D_0000 | 32'(i);
      r0 = nrd; w0 = nwr;
      cpu_op(1'b1, mk(2, i), wd, q);
      check("R5", "no fetch", 32'(nrd - r0), 0);
      check("R5", "bus write", 32'(nwr - w0), 1);
      check("R5", "memory updated", mem[(2 << 3) | i], wd);
      cpu_op(1'b0, mk(1, i), 0, q);
      check("R5", "old line kept", q, 32'h5A5A_0000 | 32'(i));
      check("R5", "old line hit", 32'(nrd - r0), 0);
    end

    // R7, R9, R10 in invalidate mode
    for (int i = 0; i < 8; i++) begin
      snoop(1'b1, mk(3, i), 32'hBAD0_0000, OTHER);
      r0 = nrd;
      cpu_op(1'b0, mk(1, i), 0, q);
      check("R9", "other tag snoop no effect", 32'(nrd - r0), 0);
      snoop(1'b0, mk(1, i), 0, OTHER);
      cpu_op(1'b0, mk(1, i), 0, q);
      check("R9", "snooped read no effect", 32'(nrd - r0), 0);
      snoop(1'b1, mk(1, i), 32'hFEED_0000, OWN);
      cpu_op(1'b0, mk(1, i), 0, q);
      check("R10", "own id not invalidated", 32'(nrd - r0), 0);
      wd = 32'hC0DE_0000 | 32'(i);
      snoop(1'b1, mk(1, i), wd, OTHER);
      cpu_op(1'b0, mk(1, i), 0, q);
      check("R7", "invalidated line refetched", 32'(nrd - r0), 1);
      check("R7", "fresh data", q, wd);
    end

    // R8, R10 in update mode
    cfg_upd = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wd = 32'h0BAD_F000 | 32'(i);
      r0 = nrd;
      snoop(1'b1, mk(1, i), wd, OTHER);
      cpu_op(1'b0, mk(1, i), 0, q);
      check("R8", "updated data", q, wd);
      check("R8", "line stays valid", 32'(nrd - r0), 0);
      snoop(1'b1, mk(1, i), 32'h1111_1111, OWN);
      cpu_op(1'b0, mk(1, i), 0, q);
      check("R10", "own id not applied", q, wd);
    end

    // R6 fetch-on-write
    cfg_fow = 1'b1; cfg_upd = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wd = 32'hF0F0_0000 | 32'(i);
      r0 = nrd; w0 = nwr;
      cpu_op(1'b1, mk(4, i), wd, q);
      check("R6", "fetch before write", 32'(nrd - r0), 1);
      check("R6", "bus write", 32'(nwr - w0), 1);
      cpu_op(1'b0, mk(4, i), 0, q);
      check("R6", "allocated hit", 32'(nrd - r0), 1);
      check("R6", "allocated data", q, wd);
    end

    // R11 same-index collision, in update mode
    cfg_upd = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wd = 32'h7777_0000 | 32'(i);
      r0 = nrd;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = mk(4, i);
      snp_valid = 1'b1; snp_we = 1'b1; snp_addr = mk(4, i); snp_wdata = wd; snp_src_id = 2'(OTHER);
      @(negedge clk);
      snp_valid = 1'b0;
      while (!cpu_done) @(negedge clk);
      q = cpu_rdata; cpu_req = 1'b0;
      check("R11", "collision forces miss", 32'(nrd - r0), 1);
      check("R11", "collision data", q, wd);
    end

    // R13 snoop acted on while busy with another miss
    cfg_upd = 1'b0;
    for (int i = 0; i < 8; i++) begin
      fork
        cpu_op(1'b0, mk(6, i), 0, q);
        begin @(negedge clk); snoop(1'b1, mk(4, (i + 1) % 8), 32'h3333_0000 | 32'(i), OTHER); end
      join
      r0 = nrd;
      cpu_op(1'b0, mk(4, (i + 1) % 8), 0, q);
      check("R13", "snoop during busy invalidated", 32'(nrd - r0), 1);
      check("R13", "refetched data", q, 32'h3333_0000 | 32'(i));
    end
  endtask

  initial begin
    errors = 0; checks = 0;
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule